// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block resolves the addressing of an inter-processor interrupt message among a set of local interrupt units. For one message it evaluates, for every unit in parallel, whether that unit is addressed. The message may name a physical ID, a flat logical bitmask, a cluster logical address, or a shorthand that overrides the destination field. The result is a mask of all addressed units. Each unit supplies its own identity, its logical model and whether it is present and enabled.

When the message asks for lowest-priority delivery, the block also picks exactly one target. It does not compare priorities. A rotating pointer remembers the last unit chosen, and the next eligible unit after it wins. The pointer moves only when a message strobe is sampled on a clock edge. All address matching is combinational within the cycle. Message transport and interrupt acceptance are handled elsewhere.

Top module: `irq_dest_match`

## Requirements
- R1: With shorthand 0 and destination mode 0 (physical), a present unit is targeted when the destination field equals its physical ID or is all ones (0xFF).
- R2: With shorthand 0, destination mode 1 (logical) and unit model code 2'b00 (flat), a present unit is targeted when its logical ID ANDed with the destination field is nonzero.
- R3: With shorthand 0, destination mode 1 and unit model code 2'b01 (cluster), a present unit is targeted when the upper nibbles of logical ID and destination are equal and the AND of their lower nibbles is nonzero.
- R4: With shorthand 0 and destination mode 1, a unit whose model code is 2'b10 or 2'b11 is never targeted.
- R5: Shorthand 1 targets only the unit whose index equals the sender index (none if the sender index is out of range). Shorthand 2 targets every present unit. Shorthand 3 targets every present unit except the sender. Shorthand codes ignore the destination mode and destination field.
- R6: A unit whose present bit is low never appears in the target mask.
- R7: With delivery mode 3'b001 (lowest priority), the single-target output is one-hot. It marks the first unit that is targeted and enabled, searching from the unit after the pointer and wrapping at the unit count, with the pointer itself checked last.
- R8: The pointer changes only on a clock edge where the message strobe is high and the delivery mode is lowest priority. It then takes the index of the chosen unit.
- R9: When no unit is eligible, the single-target output is all zeros and a strobe leaves the pointer where it was.
- R10: For any delivery mode other than 3'b001, the single-target output is all zeros while the target mask still shows every addressed unit.
- R11: During and right after reset, the pointer sits on the last unit, so the first search begins at unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message strobe, sampled on the clock edge |
| sender_idx | input | IDX_W | Index of the sending unit |
| shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but sender |
| dest_logical | input | 1 | 0 physical, 1 logical destination |
| dest_field | input | ID_W | Destination field |
| deliv_mode | input | 3 | Delivery mode, 3'b001 is lowest priority |
| unit_phys_id | input | NUM_UNITS*ID_W | Physical ID per unit, unit 0 in the low bits |
| unit_log_id | input | NUM_UNITS*ID_W | Logical ID per unit |
| unit_model | input | NUM_UNITS*2 | Logical model code per unit |
| unit_present | input | NUM_UNITS | Unit exists |
| unit_en | input | NUM_UNITS | Unit may receive lowest-priority delivery |
| target_mask | output | NUM_UNITS | All addressed units |
| lp_target | output | NUM_UNITS | One-hot lowest-priority choice |

## Verification
The bench builds the block with five units, so the index width is three bits. This is not a power of two, and the wrap from unit 4 back to unit 0 differs from a natural counter overflow. Sender indices 5 to 7 then exist on the port without naming any unit, which exercises the self shorthand with an out-of-range sender. Random traffic draws physical IDs and destinations from a small range, so physical hits, broadcast and all four model codes occur often. Directed cycles cover the pointer's reset position, pointer hold and the case with no eligible unit.

// File: rtl/irqdm_pkg.sv
package irqdm_pkg;
  localparam logic [1:0] SH_NONE   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

  localparam logic [1:0] MDL_FLAT    = 2'b00;
  localparam logic [1:0] MDL_CLUSTER = 2'b01;

  localparam logic [2:0] DM_LOWEST = 3'b001;
endpackage

// File: rtl/irqdm_unit_match.sv
module irqdm_unit_match
  import irqdm_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int IDX_W    = 3,
  parameter int UNIT_IDX = 0
) (
  input  logic [1:0]       shorthand,
  input  logic             dest_logical,
  input  logic [ID_W-1:0]  dest_field,
  input  logic [IDX_W-1:0] sender_idx,
  input  logic [ID_W-1:0]  phys_id,
  input  logic [ID_W-1:0]  log_id,
  input  logic [1:0]       model,
  input  logic             present,
  output logic             hit
);
  localparam int HALF = ID_W / 2;
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(UNIT_IDX);

  logic is_self;
  logic phys_hit;
  logic flat_hit;
  logic clus_hit;
  logic addr_hit;
  logic raw_hit;

  assign is_self  = (sender_idx == MY_IDX);
  assign phys_hit = (dest_field == phys_id) || (&dest_field);
  assign flat_hit = |(log_id & dest_field);
  assign clus_hit = (log_id[ID_W-1:HALF] == dest_field[ID_W-1:HALF]) &&
                    (|(log_id[HALF-1:0] & dest_field[HALF-1:0]));

  always_comb begin
    if (!dest_logical) begin
      addr_hit = phys_hit;
    end else begin
      case (model)
        MDL_FLAT:    addr_hit = flat_hit;
        MDL_CLUSTER: addr_hit = clus_hit;
        default:     addr_hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (shorthand)
      SH_SELF:   raw_hit = is_self;
      SH_ALL:    raw_hit = 1'b1;
      SH_OTHERS: raw_hit = !is_self;
      default:   raw_hit = addr_hit;
    endcase
  end

  assign hit = present && raw_hit;
endmodule

// File: rtl/irqdm_rr_pick.sv
module irqdm_rr_pick #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [NUM_UNITS-1:0] eligible,
  output logic [NUM_UNITS-1:0] pick,
  output logic                 found
);
  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(NUM_UNITS - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic [IDX_W-1:0] sel_idx;
  logic             ptr_en;

  always_comb begin
    pick    = '0;
    found   = 1'b0;
    sel_idx = ptr_q;
    for (int k = 1; k <= NUM_UNITS; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_UNITS;
      if (!found && eligible[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
        sel_idx   = IDX_W'(idx);
      end
    end
  end

  assign ptr_en = fire && found;
  assign ptr_d  = sel_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_RST;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assert_pick_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));
  assert_pick_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pick & ~eligible) == '0);
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(ptr_q));
  assert_ptr_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(|eligible)) |=> $stable(ptr_q));
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irqdm_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int ID_W      = 8,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      msg_valid,
  input  logic [IDX_W-1:0]          sender_idx,
  input  logic [1:0]                shorthand,
  input  logic                      dest_logical,
  input  logic [ID_W-1:0]           dest_field,
  input  logic [2:0]                deliv_mode,
  input  logic [NUM_UNITS*ID_W-1:0] unit_phys_id,
  input  logic [NUM_UNITS*ID_W-1:0] unit_log_id,
  input  logic [NUM_UNITS*2-1:0]    unit_model,
  input  logic [NUM_UNITS-1:0]      unit_present,
  input  logic [NUM_UNITS-1:0]      unit_en,
  output logic [NUM_UNITS-1:0]      target_mask,
  output logic [NUM_UNITS-1:0]      lp_target
);
  logic [NUM_UNITS-1:0] hit_vec;
  logic [NUM_UNITS-1:0] eligible;
  logic [NUM_UNITS-1:0] pick;
  logic                 found;
  logic                 is_lp;
  logic                 fire;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    irqdm_unit_match #(
      .ID_W    (ID_W),
      .IDX_W   (IDX_W),
      .UNIT_IDX(u)
    ) u_match (
      .shorthand   (shorthand),
      .dest_logical(dest_logical),
      .dest_field  (dest_field),
      .sender_idx  (sender_idx),
      .phys_id     (unit_phys_id[u*ID_W +: ID_W]),
      .log_id      (unit_log_id[u*ID_W +: ID_W]),
      .model       (unit_model[u*2 +: 2]),
      .present     (unit_present[u]),
      .hit         (hit_vec[u])
    );
  end

  assign is_lp    = (deliv_mode == DM_LOWEST);
  assign fire     = msg_valid && is_lp;
  assign eligible = hit_vec & unit_en;

  irqdm_rr_pick #(
    .NUM_UNITS(NUM_UNITS),
    .IDX_W    (IDX_W)
  ) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .eligible(eligible),
    .pick    (pick),
    .found   (found)
  );

  assign target_mask = hit_vec;
  assign lp_target   = is_lp ? pick : '0;

  assert_all_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shorthand == SH_ALL) |-> (target_mask == unit_present));
  assert_absent_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (target_mask & ~unit_present) == '0);
  assert_lp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lp && |(target_mask & unit_en)) |-> ($countones(lp_target) == 1));
  assert_lp_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_target & ~target_mask) == '0);
endmodule

// File: tb/irq_dest_match_test.sv
module irq_dest_match_test;
  localparam int N  = 5;
  localparam int W  = 8;
  localparam int XW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n;
  logic           msg_valid;
  logic [XW-1:0]  sender_idx;
  logic [1:0]     shorthand;
  logic           dest_logical;
  logic [W-1:0]   dest_field;
  logic [2:0]     deliv_mode;
  logic [N*W-1:0] unit_phys_id;
  logic [N*W-1:0] unit_log_id;
  logic [N*2-1:0] unit_model;
  logic [N-1:0]   unit_present;
  logic [N-1:0]   unit_en;
  logic [N-1:0]   target_mask;
  logic [N-1:0]   lp_target;

  irq_dest_match #(.NUM_UNITS(N), .ID_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .sender_idx(sender_idx),
    .shorthand(shorthand), .dest_logical(dest_logical), .dest_field(dest_field),
    .deliv_mode(deliv_mode), .unit_phys_id(unit_phys_id), .unit_log_id(unit_log_id),
    .unit_model(unit_model), .unit_present(unit_present), .unit_en(unit_en),
    .target_mask(target_mask), .lp_target(lp_target)
  );

  int total = 0;
  int bad   = 0;
  int ref_ptr;
  int exp_idx;
  bit exp_found;
  int phys [N];
  int logi [N];
  int mdl  [N];

  task automatic pack_ids();
    for (int u = 0; u < N; u++) begin
      unit_phys_id[u*W +: W] = W'(phys[u]);
      unit_log_id[u*W +: W]  = W'(logi[u]);
      unit_model[u*2 +: 2]   = 2'(mdl[u]);
    end
  endtask

  function automatic bit ref_hit(int u);
    int d;
    d = int'(dest_field);
    if (!unit_present[u]) return 0;
    case (int'(shorthand))
      1: return int'(sender_idx) == u;
      2: return 1;
      3: return int'(sender_idx) != u;
      default: begin
        if (!dest_logical) return (d == phys[u]) || (d == 255);
        if (mdl[u] == 0) return (logi[u] & d) != 0;
        if (mdl[u] == 1) return ((logi[u] / 16) == (d / 16)) && ((logi[u] & d & 15) != 0);
        return 0;
      end
    endcase
  endfunction

  task automatic compare(string tag);
    logic [N-1:0] em;
    logic [N-1:0] el;
    string mt;
    string lt;
    em = '0;
    el = '0;
    for (int u = 0; u < N; u++) em[u] = ref_hit(u);
    exp_found = 0;
    exp_idx   = ref_ptr;
    for (int k = 1; k <= N; k++) begin
      int i;
      i = (ref_ptr + k) % N;
      if (!exp_found && em[i] && unit_en[i]) begin
        exp_found = 1;
        exp_idx   = i;
      end
    end
    if (deliv_mode == 3'b001 && exp_found) el[exp_idx] = 1'b1;
    if (tag != "") begin
      mt = tag;
      lt = tag;
    end else begin
      if (shorthand != 2'd0) mt = "R5";
      else if (!dest_logical) mt = "R1";
      else if (mdl[0] == 0) mt = "R2";
      else mt = "R3/R4";
      lt = (deliv_mode == 3'b001) ? "R7" : "R10";
    end
    total++;
    if (target_mask !== em) begin
      bad++;
      $display("FAIL %s target_mask actual=%b expected=%b", mt, target_mask, em);
    end
    total++;
    if (lp_target !== el) begin
      bad++;
      $display("FAIL %s lp_target actual=%b expected=%b", lt, lp_target, el);
    end
  endtask

  task automatic step(string tag);
    pack_ids();
    #1;
    compare(tag);
    @(posedge clk);
    if (rst_n && msg_valid && deliv_mode == 3'b001 && exp_found) ref_ptr = exp_idx;
    @(negedge clk);
  endtask

  initial begin
    #500us;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ref_ptr = N - 1;
    msg_valid = 1'b1;
    sender_idx = '0;
    shorthand = 2'd2;
    dest_logical = 1'b0;
    dest_field = '0;
    deliv_mode = 3'b001;
    unit_present = '1;
    unit_en = '1;
    for (int u = 0; u < N; u++) begin
      phys[u] = 10 + u;
      logi[u] = 1 << u;
      mdl[u]  = 0;
    end
    @(negedge clk);
    step("R11");
    step("R11");
    rst_n = 1'b1;
    // R8: successive strobes walk the pointer
    for (int i = 0; i < 7; i++) step("R8");
    // R9: nobody eligible, pointer stays
    unit_en = '0;
    step("R9");
    step("R9");
    unit_en = '1;
    step("R9");
    // R8: no strobe, pointer holds
    msg_valid = 1'b0;
    step("R8");
    step("R8");
    msg_valid = 1'b1;
    // R6: absent unit
    unit_present = 5'b11011;
    deliv_mode = 3'b000;
    step("R6");
    unit_present = '1;
    // R1 physical
    shorthand = 2'd0;
    dest_field = 8'd12;
    step("R1");
    dest_field = 8'hFF;
    step("R1");
    dest_field = 8'd9;
    step("R1");
    // R2 flat
    dest_logical = 1'b1;
    dest_field = 8'h05;
    step("R2");
    // R3 cluster
    for (int u = 0; u < N; u++) mdl[u] = 1;
    logi[0] = 8'h21; logi[1] = 8'h22; logi[2] = 8'h31; logi[3] = 8'h24; logi[4] = 8'h2F;
    dest_field = 8'h23;
    step("R3");
    // R4 unknown model
    for (int u = 0; u < N; u++) mdl[u] = 2 + (u % 2);
    dest_field = 8'hFF;
    step("R4");
    // R5 shorthands
    sender_idx = 3'd3;
    shorthand = 2'd1;
    step("R5");
    shorthand = 2'd3;
    step("R5");
    sender_idx = 3'd6;
    shorthand = 2'd1;
    step("R5");
    // R10 non-lowest modes
    shorthand = 2'd2;
    deliv_mode = 3'b000;
    step("R10");
    deliv_mode = 3'b100;
    step("R10");
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      msg_valid    = 1'($urandom_range(0, 3) != 0);
      sender_idx   = 3'($urandom_range(0, 7));
      shorthand    = 2'($urandom_range(0, 3));
      dest_logical = 1'($urandom_range(0, 1));
      dest_field   = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
      deliv_mode   = ($urandom_range(0, 1) == 1) ? 3'b001 : 3'($urandom_range(0, 7));
      unit_present = N'($urandom_range(0, 31) | $urandom_range(0, 31));
      unit_en      = N'($urandom_range(0, 31) | $urandom_range(0, 31));
      for (int u = 0; u < N; u++) begin
        phys[u] = $urandom_range(0, 7);
        logi[u] = $urandom_range(0, 255);
        mdl[u]  = ($urandom_range(0, 5) == 0) ? $urandom_range(2, 3) : $urandom_range(0, 1);
      end
      if (shorthand == 2'd0 && !dest_logical && dest_field != 8'hFF)
        dest_field = 8'($urandom_range(0, 7));
      step("");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule